// File: doc/BRIEF.md
# Multicore Inter-Processor Interrupt Controller

This block lets any core of an N-core system interrupt any other core. The register space is divided into one 8-byte window per core. A core that wants to signal another core writes a command word to the control register in its own window. The word names the destination core and carries a 16-bit message.

On that write the controller sets the destination's pending flag. It also records the sender's index and the message where the destination can read them, and raises the destination's interrupt line. The destination reads its own status register to learn who called and why. It then writes an acknowledge command to its own control register, which drops the flag and the line.

Every core has its own write port and its own read port, so several cores can issue commands in the same cycle. Fixed priority rules settle every collision, so the result of any combination of writes is fully determined.

Top module: `ipi_ctrl`

## Requirements
- R1: Window k (k = 0..N-1) occupies byte offsets 8k to 8k+7. The control register is at offset 8k and the status register at 8k+4, both 32 bits wide. Byte address 0 of a word travels on data bits 31:24. Address bits 1:0 are ignored.
- R2: A control write with bit 30 (generate) set to window s, with bits 29:16 = d < N and bits 15:0 = m, makes core d's status read {bit31 0, bit30 1, bits 29:16 = s, bits 15:0 = m} after the next clock edge.
- R3: irq[d] is high exactly while core d's pending flag (status bit 30) is set.
- R4: A control write with bit 31 (acknowledge) set to window d, when no generate targets d in that cycle, clears core d's pending flag and irq[d] after the next clock edge.
- R5: A generate whose destination field is N or greater changes no pending flag, sender field or message.
- R6: When a generate and an acknowledge reach the same core in one cycle, the flag stays set and the new sender and message are captured.
- R7: When several windows send a generate to one destination in one cycle, the lowest-numbered sender's index and message are captured.
- R8: Writes to a status offset have no effect. A read of any control offset returns 0.
- R9: When several ports write the same control register in one cycle, only the lowest-numbered port's word takes effect.
- R10: After a synchronous active-low reset, every pending flag, irq line, sender field and message reads 0.
- R11: A generate to a core whose flag is already set overwrites the sender and message, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | N | Per-port write strobe |
| wr_addr | input | N*AW | Per-port byte address, port p in bits [p*AW +: AW] |
| wr_data | input | N*32 | Per-port write word, port p in bits [p*32 +: 32] |
| rd_addr | input | N*AW | Per-port read address |
| rd_data | output | N*32 | Per-port read word, combinational from rd_addr |
| irq | output | N | Per-core interrupt line |

## Verification
The bench begins with directed cases: a single generate, an acknowledge, out-of-range destinations (N and 0x3FFF), a generate and an acknowledge on the same core, two senders to one core, two ports on one window, a status write and a control read. Each of these separates one of the priority rules from its wrong alternative. It then runs a long stretch of random traffic from a fixed seed, in which every port writes random windows, offsets and destination fields. Many of those destinations fall out of range, and collisions happen often. After every cycle all status words and irq lines are compared against a reference model in the bench.

// File: rtl/ipi_pkg.sv
// Shared field positions and the decoded command type for the IPI controller.
package ipi_pkg;
    localparam int WORD_W  = 32;
    localparam int ACK_BIT = 31;
    localparam int GEN_BIT = 30;
    localparam int DST_LSB = 16;
    localparam int DST_W   = 14;
    localparam int MSG_W   = 16;

    typedef struct packed {
        logic             gen;
        logic             ack;
        logic [DST_W-1:0] dst;
        logic [MSG_W-1:0] msg;
    } ipi_cmd_t;

    // Split a control word into its command fields.
    function automatic ipi_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        ipi_cmd_t c;
        c.gen = w[GEN_BIT];
        c.ack = w[ACK_BIT];
        c.dst = w[DST_LSB +: DST_W];
        c.msg = w[MSG_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/ipi_decode.sv
// Maps the per-port writes onto per-window control commands.
// Assumes: byte addresses, 8-byte windows; only offset 0 (control) is writable.
// The lowest-numbered port that hits a window's control register wins.
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int N   = 4,
    parameter int WIW = 2,
    parameter int AW  = 5
) (
    input  logic [N-1:0]          wr_en,
    input  logic [N*AW-1:0]       wr_addr,
    input  logic [N*WORD_W-1:0]   wr_data,
    output logic [N-1:0]          cmd_vld,
    output ipi_cmd_t              cmd [N]
);
    // Pick, for each window, the first port writing its control offset.
    always_comb begin
        for (int w = 0; w < N; w++) begin
            cmd_vld[w] = 1'b0;
            cmd[w]     = '0;
            for (int p = N - 1; p >= 0; p--) begin
                if (wr_en[p] &&
                    wr_addr[p*AW+3 +: WIW] == WIW'(w) &&
                    !wr_addr[p*AW+2]) begin
                    cmd_vld[w] = 1'b1;
                    cmd[w]     = unpack_cmd(wr_data[p*WORD_W +: WORD_W]);
                end
            end
        end
    end
endmodule

// File: rtl/ipi_route.sv
// Turns per-window commands into per-destination generate and acknowledge events.
// Assumes: the sending window is the sender's index; destinations >= N never match.
// The lowest-numbered sender wins a shared destination.
module ipi_route
    import ipi_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       cmd_vld,
    input  ipi_cmd_t           cmd [N],
    output logic [N-1:0]       gen_hit,
    output logic [N-1:0]       ack_hit,
    output logic [SW-1:0]      gen_src [N],
    output logic [MSG_W-1:0]   gen_msg [N]
);
    // Search the senders from the highest down so that the lowest one is kept.
    always_comb begin
        for (int d = 0; d < N; d++) begin
            gen_hit[d] = 1'b0;
            gen_src[d] = '0;
            gen_msg[d] = '0;
            ack_hit[d] = cmd_vld[d] && cmd[d].ack;
            for (int s = N - 1; s >= 0; s--) begin
                if (cmd_vld[s] && cmd[s].gen && cmd[s].dst == DST_W'(d)) begin
                    gen_hit[d] = 1'b1;
                    gen_src[d] = SW'(s);
                    gen_msg[d] = cmd[s].msg;
                end
            end
        end
    end

    for (genvar d = 0; d < N; d++) begin : g_chk
        // R7
        src_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_hit[d] |-> (cmd_vld[gen_src[d]] && cmd[gen_src[d]].gen &&
                            cmd[gen_src[d]].msg == gen_msg[d]));
    end
endmodule

// File: rtl/ipi_slot.sv
// Holds one core's pending flag together with the captured sender and message.
// Assumes: generate has priority over acknowledge.
module ipi_slot
    import ipi_pkg::*;
#(
    parameter int SW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen,
    input  logic             ack,
    input  logic [SW-1:0]    src,
    input  logic [MSG_W-1:0] msg,
    output logic             pend,
    output logic [SW-1:0]    src_q,
    output logic [MSG_W-1:0] msg_q
);
    // Update the pending flag and latch the sender data on a generate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            src_q <= '0;
            msg_q <= '0;
        end else if (gen) begin
            pend  <= 1'b1;
            src_q <= src;
            msg_q <= msg;
        end else if (ack) begin
            pend  <= 1'b0;
        end
    end

    // R2
    gen_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen |=> (pend && src_q == $past(src) && msg_q == $past(msg)));
    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !gen) |=> !pend);
    // R5
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen && !ack) |=> ($stable(pend) && $stable(src_q) && $stable(msg_q)));
endmodule

// File: rtl/ipi_ctrl.sv
// Top of the inter-processor interrupt controller: N cores, each with its
// own write and read port onto N 8-byte windows (control at +0, status at +4).
// Assumes: N is a power of two; bus words carry byte 0 on bits 31:24.
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int N  = 4,
    localparam int WIW = (N > 1) ? $clog2(N) : 1,
    localparam int AW  = WIW + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr_en,
    input  logic [N*AW-1:0]     wr_addr,
    input  logic [N*32-1:0]     wr_data,
    input  logic [N*AW-1:0]     rd_addr,
    output logic [N*32-1:0]     rd_data,
    output logic [N-1:0]        irq
);
    localparam int SW = WIW;

    logic [N-1:0]       cmd_vld;
    ipi_cmd_t           cmd [N];
    logic [N-1:0]       gen_hit;
    logic [N-1:0]       ack_hit;
    logic [SW-1:0]      gen_src [N];
    logic [MSG_W-1:0]   gen_msg [N];
    logic [N-1:0]       pend;
    logic [SW-1:0]      src_q [N];
    logic [MSG_W-1:0]   msg_q [N];

    ipi_decode #(.N(N), .WIW(WIW), .AW(AW)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_vld(cmd_vld), .cmd(cmd)
    );

    ipi_route #(.N(N), .SW(SW)) u_route (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd),
        .gen_hit(gen_hit), .ack_hit(ack_hit),
        .gen_src(gen_src), .gen_msg(gen_msg)
    );

    for (genvar k = 0; k < N; k++) begin : g_slot
        ipi_slot #(.SW(SW)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .gen(gen_hit[k]), .ack(ack_hit[k]),
            .src(gen_src[k]), .msg(gen_msg[k]),
            .pend(pend[k]), .src_q(src_q[k]), .msg_q(msg_q[k])
        );
    end

    assign irq = pend;

    // Return the addressed window's status word, or 0 for a control offset.
    always_comb begin
        for (int p = 0; p < N; p++) begin
            logic [WIW-1:0] win;
            win = rd_addr[p*AW+3 +: WIW];
            if (rd_addr[p*AW+2])
                rd_data[p*32 +: 32] = {1'b0, pend[win], DST_W'(src_q[win]), msg_q[win]};
            else
                rd_data[p*32 +: 32] = '0;
        end
    end

    // R6
    gen_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_hit[0] && ack_hit[0]) |=> irq[0]);
    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> $past(gen_hit[0]));
endmodule

// File: tb/sim_ipi_ctrl.sv
// Self-checking bench: directed corners, then seeded random traffic against a model.
module sim_ipi_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 5;

    logic clk = 0;
    logic rst_n = 0;
    logic [N-1:0]    wr_en;
    logic [N*AW-1:0] wr_addr;
    logic [N*32-1:0] wr_data;
    logic [N*AW-1:0] rd_addr;
    logic [N*32-1:0] rd_data;
    logic [N-1:0]    irq;

    logic [AW-1:0] b_addr [N];
    logic [31:0]   b_data [N];
    logic [N-1:0]  b_en;

    logic          m_pend [N];
    logic [13:0]   m_src [N];
    logic [15:0]   m_msg [N];

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_ctrl #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always_comb begin
        wr_en = b_en;
        for (int p = 0; p < N; p++) begin
            wr_addr[p*AW +: AW] = b_addr[p];
            wr_data[p*32 +: 32] = b_data[p];
        end
    end

    function automatic logic [31:0] ctl(input bit g, input bit a, input int d, input int m);
        return {a, g, 14'(d), 16'(m)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one write set in the model (priority rules of R2, R4-R7, R9).
    task automatic model_step();
        bit vld [N];
        logic [31:0] w [N];
        for (int win = 0; win < N; win++) begin
            vld[win] = 0; w[win] = '0;
            for (int p = N - 1; p >= 0; p--)
                if (b_en[p] && b_addr[p][4:3] == 2'(win) && !b_addr[p][2]) begin
                    vld[win] = 1; w[win] = b_data[p];
                end
        end
        for (int d = 0; d < N; d++) begin
            bit hit = 0;
            for (int s = 0; s < N && !hit; s++)
                if (vld[s] && w[s][30] && w[s][29:16] == 14'(d)) begin
                    hit = 1; m_src[d] = 14'(s); m_msg[d] = w[s][15:0];
                end
            if (hit) m_pend[d] = 1;
            else if (vld[d] && w[d][31]) m_pend[d] = 0;
        end
    endtask

    task automatic idle();
        b_en = '0;
        for (int p = 0; p < N; p++) begin b_addr[p] = '0; b_data[p] = '0; end
    endtask

    task automatic cycle(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        idle();
        for (int p = 0; p < N; p++) rd_addr[p*AW +: AW] = AW'(8*p + 4);
        #1;
        for (int k = 0; k < N; k++) begin
            chk(req, rd_data[k*32 +: 32], {1'b0, m_pend[k], m_src[k], m_msg[k]});
            chk({req, "/R3"}, 32'(irq[k]), 32'(m_pend[k]));
        end
    endtask

    task automatic put(input int p, input int addr, input logic [31:0] d);
        b_en[p] = 1'b1; b_addr[p] = AW'(addr); b_data[p] = d;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed = 32'h1F2E3D4C;
        idle();
        rd_addr = '0;
        for (int k = 0; k < N; k++) begin m_pend[k] = 0; m_src[k] = 0; m_msg[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cycle("R10 reset");

        put(1, 8*1, ctl(1, 0, 2, 16'hBEEF)); cycle("R2 single generate");
        put(2, 8*2, ctl(0, 1, 0, 0));        cycle("R4 acknowledge");
        put(0, 8*0, ctl(1, 0, 4, 16'h1111));
        put(3, 8*3, ctl(1, 0, 14'h3FFF, 16'h2222)); cycle("R5 out of range");
        put(0, 8*0, ctl(1, 0, 3, 16'h0A0A)); cycle("R2 setup");
        put(1, 8*3, ctl(0, 1, 0, 0));
        put(2, 8*2, ctl(1, 0, 3, 16'h0B0B)); cycle("R6 gen beats ack");
        put(3, 8*3, ctl(1, 0, 1, 16'h3333));
        put(2, 8*0, ctl(1, 0, 1, 16'h4444)); cycle("R7 lowest sender");
        put(3, 8*2, ctl(1, 0, 0, 16'h7777));
        put(1, 8*2, ctl(1, 0, 0, 16'h5555)); cycle("R9 lowest port");
        put(0, 8*1+4, ctl(0, 1, 0, 0));
        put(1, 8*0+4, ctl(1, 0, 0, 16'h9999)); cycle("R8 status write");
        put(2, 8*1, ctl(1, 0, 0, 16'hCAFE)); cycle("R11 overwrite");
        put(0, 8*1+1, ctl(0, 1, 0, 0));      cycle("R1 low address bits ignored");
        rd_addr[0 +: AW] = AW'(8*2); #1;
        chk("R8 control reads zero", rd_data[31:0], 32'h0);
        rd_addr[AW +: AW] = AW'(8*0 + 4 + 3); #1;
        chk("R1 status offset", rd_data[63:32], {1'b0, m_pend[0], m_src[0], m_msg[0]});

        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < N; p++)
                if ($urandom_range(0, 2) == 0)
                    put(p, $urandom_range(0, 8*N - 1),
                        ctl($urandom_range(0, 1), $urandom_range(0, 3) == 0,
                            ($urandom_range(0, 7) == 0) ? $urandom_range(0, 16383)
                                                         : $urandom_range(0, N + 1),
                            $urandom_range(0, 65535)));
            cycle("R2 random traffic");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule